// File: doc/BRIEF.md
# Pixel Mask and Palette Select Stage

This block is the first pixel stage of a palette system in which several devices share one video output. Each clock it takes an 8-bit red, green and blue sample. It ANDs every colour byte with one mask byte that all three channels share. Mask bit k gates bit k of red, green and blue alike. An all-ones mask lets the pixel through unchanged.

A two-bit select bus from outside is compared with two match bits that the host programs. The device owns the output only when both bits agree. When they do not, the colour outputs are forced to zero, so another device can drive the shared video path.

In test mode, a capture register takes the raw, unmasked pixel word so the host can read back what arrived at the pixel inputs. All results are registered, which gives one clock of latency from input to output.

Top module: `pxm_front_stage`

## Requirements
- R1: While reset is asserted, and on the first clock after it, the colour outputs, `out_valid_o`, `selected_o` and `cap_o` are all zero.
- R2: One clock after a valid, selected pixel, each colour output equals that channel's input ANDed with `mask_i`. Mask bit k gates bit k of red, green and blue.
- R3: With `mask_i` = 8'hFF and the device selected, each colour output equals its input one clock later.
- R4: `selected_o` is 1 one clock after a cycle where `psel_i[1]` == `match_i[1]` and `psel_i[0]` == `match_i[0]`, and 0 after any cycle where either bit differs.
- R5: One clock after a cycle where the select bits do not match, all three colour outputs are zero, whatever the pixel and mask.
- R6: The select decision is taken again every clock, so alternating `psel_i` on consecutive pixels alternates between passed and zeroed outputs one clock later.
- R7: On a clock where `test_en_i` and `pix_valid_i` are both 1, `cap_o` loads the unmasked word {red, green, blue}, red in bits 23:16 and blue in bits 7:0. This is seen one clock later, even when the device is not selected.
- R8: On a clock where `test_en_i` is 0, `cap_o` keeps its value, whatever the pixel inputs.
- R9: One clock after a cycle with `pix_valid_i` = 0, `out_valid_o` is 0 and all colour outputs are zero. After a valid cycle, `out_valid_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid_i | input | 1 | Pixel inputs carry a sample this clock |
| red_i | input | 8 | Red pixel input |
| grn_i | input | 8 | Green pixel input |
| blu_i | input | 8 | Blue pixel input |
| mask_i | input | 8 | Shared per-bit pixel mask |
| match_i | input | 2 | Programmed select match bits |
| psel_i | input | 2 | External select inputs |
| test_en_i | input | 1 | Test mode: enables pixel capture |
| red_o | output | 8 | Masked, gated red output |
| grn_o | output | 8 | Masked, gated green output |
| blu_o | output | 8 | Masked, gated blue output |
| out_valid_o | output | 1 | Colour outputs carry a pixel |
| selected_o | output | 1 | Device owned the output on the previous clock |
| cap_o | output | 24 | Captured raw pixel word {red, green, blue} |

## Verification
Two behaviours are hard to reach from the ports. The first is a capture register that must hold through a long stream of changing pixels once test mode drops. The second is a select decision that must follow a select bus toggling on every clock with no lag.

The stimulus first fills the capture register while the device is deselected. This shows that capture does not depend on ownership. It then turns test mode off and streams pixels with a new value every clock, checking that `cap_o` never moves. A separate burst flips `psel_i` on every pixel, so that one stale cycle in the select path would hand a pixel to the wrong device.

// File: rtl/pxm_pkg.sv
package pxm_pkg;
  localparam int NCH = 3;
  typedef enum logic [1:0] {CH_BLU = 2'd0, CH_GRN = 2'd1, CH_RED = 2'd2} chan_e;
endpackage

// File: rtl/pxm_select_match.sv
module pxm_select_match #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] match_i,
  input  logic [SEL_W-1:0] psel_i,
  output logic             hit_now_o,
  output logic             sel_q_o
);
  logic [SEL_W-1:0] bit_eq;

  genvar gi;
  generate
    for (gi = 0; gi < SEL_W; gi++) begin : g_cmp
      assign bit_eq[gi] = ~(psel_i[gi] ^ match_i[gi]);
    end
  endgenerate

  assign hit_now_o = &bit_eq;

  always_ff @(posedge clk) begin
    if (rst) sel_q_o <= 1'b0;
    else     sel_q_o <= hit_now_o;
  end

  // R4: registered select follows the previous cycle's compare of the two buses
  assert_sel_match_R4: assert property (@(posedge clk) disable iff (rst)
    (psel_i == match_i) |=> sel_q_o);
  assert_sel_miss_R4: assert property (@(posedge clk) disable iff (rst)
    (psel_i != match_i) |=> !sel_q_o);
endmodule

// File: rtl/pxm_mask_lane.sv
module pxm_mask_lane #(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_i,
  input  logic [PIX_W-1:0] dat_i,
  input  logic [PIX_W-1:0] mask_i,
  output logic [PIX_W-1:0] dat_o
);
  always_ff @(posedge clk) begin
    if (rst)       dat_o <= '0;
    else if (ld_i) dat_o <= dat_i & mask_i;
    else           dat_o <= '0;
  end

  // R2: masked value appears one clock after a load
  assert_mask_lane_R2: assert property (@(posedge clk) disable iff (rst)
    ld_i |=> (dat_o & ~$past(mask_i)) == '0);
  // R5/R9: no load leaves the lane dark
  assert_lane_dark_R5: assert property (@(posedge clk) disable iff (rst)
    !ld_i |=> dat_o == '0);
endmodule

// File: rtl/pxm_test_capture.sv
module pxm_test_capture #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_i,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] cap_o
);
  always_ff @(posedge clk) begin
    if (rst)       cap_o <= '0;
    else if (en_i) cap_o <= word_i;
  end

  // R8: capture holds when not enabled
  assert_cap_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> $stable(cap_o));
endmodule

// File: rtl/pxm_front_stage.sv
module pxm_front_stage #(
  parameter int PIX_W = 8,
  parameter int SEL_W = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         pix_valid_i,
  input  logic [PIX_W-1:0]             red_i,
  input  logic [PIX_W-1:0]             grn_i,
  input  logic [PIX_W-1:0]             blu_i,
  input  logic [PIX_W-1:0]             mask_i,
  input  logic [SEL_W-1:0]             match_i,
  input  logic [SEL_W-1:0]             psel_i,
  input  logic                         test_en_i,
  output logic [PIX_W-1:0]             red_o,
  output logic [PIX_W-1:0]             grn_o,
  output logic [PIX_W-1:0]             blu_o,
  output logic                         out_valid_o,
  output logic                         selected_o,
  output logic [pxm_pkg::NCH*PIX_W-1:0] cap_o
);
  import pxm_pkg::*;
  localparam int WORD_W = NCH * PIX_W;

  logic [NCH-1:0][PIX_W-1:0] pix_in;
  logic [NCH-1:0][PIX_W-1:0] pix_out;
  logic                      hit_now;
  logic                      lane_ld;
  logic                      valid_q;

  assign pix_in[CH_RED] = red_i;
  assign pix_in[CH_GRN] = grn_i;
  assign pix_in[CH_BLU] = blu_i;

  pxm_select_match #(.SEL_W(SEL_W)) u_sel (
    .clk(clk), .rst(rst), .match_i(match_i), .psel_i(psel_i),
    .hit_now_o(hit_now), .sel_q_o(selected_o)
  );

  assign lane_ld = pix_valid_i & hit_now;

  genvar ci;
  generate
    for (ci = 0; ci < NCH; ci++) begin : g_lane
      pxm_mask_lane #(.PIX_W(PIX_W)) u_lane (
        .clk(clk), .rst(rst), .ld_i(lane_ld),
        .dat_i(pix_in[ci]), .mask_i(mask_i), .dat_o(pix_out[ci])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else     valid_q <= pix_valid_i;
  end

  pxm_test_capture #(.W(WORD_W)) u_cap (
    .clk(clk), .rst(rst), .en_i(test_en_i & pix_valid_i),
    .word_i(pix_in), .cap_o(cap_o)
  );

  assign red_o       = pix_out[CH_RED];
  assign grn_o       = pix_out[CH_GRN];
  assign blu_o       = pix_out[CH_BLU];
  assign out_valid_o = valid_q;

  // R5: a deselected device shows black on all channels
  assert_unsel_dark_R5: assert property (@(posedge clk) disable iff (rst)
    !selected_o |-> (red_o == '0 && grn_o == '0 && blu_o == '0));
  // R9: no valid pixel means dark outputs
  assert_novalid_dark_R9: assert property (@(posedge clk) disable iff (rst)
    !out_valid_o |-> (red_o == '0 && grn_o == '0 && blu_o == '0));
  // R7: a test-mode pixel is captured unmasked
  assert_cap_load_R7: assert property (@(posedge clk) disable iff (rst)
    (test_en_i && pix_valid_i) |=> cap_o[WORD_W-1 -: PIX_W] == $past(red_i));
endmodule

// File: tb/pxm_front_stage_tb_top.sv
module pxm_front_stage_tb_top;
  typedef struct {
    logic [7:0]  r, g, b;
    logic        vld, sel;
    logic [23:0] cap;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pix_valid_i = 1'b0;
  logic [7:0] red_i = '0, grn_i = '0, blu_i = '0, mask_i = 8'hFF;
  logic [1:0] match_i = '0, psel_i = '0;
  logic test_en_i = 1'b0;
  logic [7:0] red_o, grn_o, blu_o;
  logic out_valid_o, selected_o;
  logic [23:0] cap_o;

  int errors = 0;
  int checks = 0;
  exp_t q[$];
  logic [23:0] model_cap = '0;
  bit done = 0;

  always #5 clk = ~clk;

  pxm_front_stage dut_i (
    .clk(clk), .rst(rst), .pix_valid_i(pix_valid_i),
    .red_i(red_i), .grn_i(grn_i), .blu_i(blu_i), .mask_i(mask_i),
    .match_i(match_i), .psel_i(psel_i), .test_en_i(test_en_i),
    .red_o(red_o), .grn_o(grn_o), .blu_o(blu_o),
    .out_valid_o(out_valid_o), .selected_o(selected_o), .cap_o(cap_o)
  );

  task automatic drive(input logic [7:0] r, g, b, m, input logic [1:0] mt, ps,
                       input logic v, te, input string tag);
    exp_t e;
    logic hit;
    @(negedge clk);
    red_i = r; grn_i = g; blu_i = b; mask_i = m;
    match_i = mt; psel_i = ps; pix_valid_i = v; test_en_i = te;
    hit = (ps == mt);
    if (v && te) model_cap = {r, g, b};
    e.r = (v && hit) ? (r & m) : 8'h00;
    e.g = (v && hit) ? (g & m) : 8'h00;
    e.b = (v && hit) ? (b & m) : 8'h00;
    e.vld = v; e.sel = hit; e.cap = model_cap; e.tag = tag;
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (red_o !== e.r || grn_o !== e.g || blu_o !== e.b || out_valid_o !== e.vld ||
          selected_o !== e.sel || cap_o !== e.cap) begin
        errors++;
        $display("FAIL %s: got rgb=%h_%h_%h v=%b s=%b cap=%h exp rgb=%h_%h_%h v=%b s=%b cap=%h",
                 e.tag, red_o, grn_o, blu_o, out_valid_o, selected_o, cap_o,
                 e.r, e.g, e.b, e.vld, e.sel, e.cap);
      end
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #200_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout exp completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: state while reset is held
    checks++;
    if ({red_o, grn_o, blu_o, out_valid_o, selected_o, cap_o} !== '0) begin
      errors++;
      $display("FAIL R1: got rgb=%h_%h_%h v=%b s=%b cap=%h exp all zero",
               red_o, grn_o, blu_o, out_valid_o, selected_o, cap_o);
    end
    rst = 1'b0;
    // R1: first clock after reset, no valid pixel, select mismatch
    drive(8'h00, 8'h00, 8'h00, 8'hFF, 2'b10, 2'b01, 1'b0, 1'b0, "R1");
    // R3: all-ones mask passes data
    drive(8'h12, 8'h34, 8'h56, 8'hFF, 2'b10, 2'b10, 1'b1, 1'b0, "R3");
    drive(8'hFF, 8'h00, 8'hA5, 8'hFF, 2'b10, 2'b10, 1'b1, 1'b0, "R3");
    // R2: shared mask on all lanes
    drive(8'hFF, 8'hFF, 8'hFF, 8'h0F, 2'b10, 2'b10, 1'b1, 1'b0, "R2");
    drive(8'hC3, 8'h5A, 8'h99, 8'hA5, 2'b10, 2'b10, 1'b1, 1'b0, "R2");
    for (int k = 0; k < 8; k++)
      drive(8'hFF, 8'hFF, 8'hFF, 8'(1 << k), 2'b01, 2'b01, 1'b1, 1'b0, "R2");
    // R4/R5: every mismatch pattern
    drive(8'h77, 8'h88, 8'h99, 8'hFF, 2'b10, 2'b00, 1'b1, 1'b0, "R5");
    drive(8'h77, 8'h88, 8'h99, 8'hFF, 2'b10, 2'b11, 1'b1, 1'b0, "R5");
    drive(8'h77, 8'h88, 8'h99, 8'hFF, 2'b10, 2'b01, 1'b1, 1'b0, "R4");
    drive(8'h77, 8'h88, 8'h99, 8'hFF, 2'b11, 2'b11, 1'b1, 1'b0, "R4");
    drive(8'h77, 8'h88, 8'h99, 8'hFF, 2'b00, 2'b00, 1'b1, 1'b0, "R4");
    // R6: select toggles each pixel
    for (int k = 0; k < 10; k++)
      drive(8'(k * 17), 8'(k * 5 + 1), 8'(255 - k), 8'hFF, 2'b01,
            (k % 2 == 0) ? 2'b01 : 2'b10, 1'b1, 1'b0, "R6");
    // R9: no valid pixel
    drive(8'hAB, 8'hCD, 8'hEF, 8'hFF, 2'b01, 2'b01, 1'b0, 1'b0, "R9");
    drive(8'hAB, 8'hCD, 8'hEF, 8'hFF, 2'b01, 2'b01, 1'b1, 1'b0, "R9");
    // R7: capture while deselected, unmasked
    drive(8'hDE, 8'hAD, 8'hBE, 8'h00, 2'b01, 2'b10, 1'b1, 1'b1, "R7");
    drive(8'h11, 8'h22, 8'h33, 8'h0F, 2'b01, 2'b01, 1'b1, 1'b1, "R7");
    // R7: test mode with no valid pixel leaves capture alone
    drive(8'h44, 8'h55, 8'h66, 8'hFF, 2'b01, 2'b01, 1'b0, 1'b1, "R7");
    // R8: streaming with test mode off keeps capture
    for (int k = 0; k < 12; k++)
      drive(8'(k * 31), 8'(k * 7), 8'(k * 13 + 3), 8'hFF, 2'b01, 2'b01, 1'b1, 1'b0, "R8");
    drive(8'h00, 8'h00, 8'h00, 8'hFF, 2'b01, 2'b01, 1'b0, 1'b0, "R8");
    repeat (3) @(negedge clk);
    done = 1;
    finish_run();
  end
endmodule